// File: doc/BRIEF.md
# Periodic Fetch Time-Slice Arbiter

This block decides, cycle by cycle within each bus (micro)frame, whether a descriptor-driven DMA engine should fetch data for periodic IN endpoints or for non-periodic endpoints. A position counter restarts on every start-of-frame strobe and counts clock cycles up to the programmed frame length. While a periodic endpoint is active and scatter/gather operation is enabled, periodic requests win for an opening slice of the frame. The slice is a quarter, a half or three quarters of the frame, chosen by a two-bit code. Once the slice has elapsed, the grant moves to non-periodic requests for the rest of that frame.

The grant only moves between transfers. A new decision is taken when no grant is held, or in the cycle in which the current transfer reports completion, so a burst already under way is never cut off. The reserved slice code is served as a quarter of the frame and raises an error flag. That flag stays set until reset.

Top module: `pft_arbiter`

## Requirements
- R1: While `rst` is high on a clock edge, and after it, `grant_o` is 2'b00, `per_window_o` is 0 and `code_err_o` is 0. The periodic window stays closed until the first `sof_i` after reset.
- R2: The boundary is `(frame_len_i * Q) >> 2`, where Q is 1 for code 2'b00, 2 for 2'b01 and 3 for 2'b10. A `sof_i` seen on an edge sets the position to 0, and the position then rises by one per cycle. The window is open while the position is below the boundary. `per_window_o` shows that state one clock later, so after each `sof_i` it is high for exactly boundary-many cycles.
- R3: Code 2'b11 gives the same boundary as 2'b00. Any edge that samples code 2'b11 sets `code_err_o` on the next cycle, and the flag then stays set until reset.
- R4: When `sg_mode_i` is low, the window is closed.
- R5: When `per_active_i` is low, the window is closed. The code then has no effect on the grant.
- R6: At a decision point inside the window, a pending periodic request gets `grant_o = 2'b01`. A non-periodic request gets `grant_o = 2'b10` only if no periodic request is pending.
- R7: At a decision point outside the window, a non-periodic request gets 2'b10. A periodic request gets 2'b01 only if no non-periodic request is pending. With no request, the grant becomes 2'b00.
- R8: A decision point is an edge at which `grant_o` is 2'b00 or `xfer_done_i` is high. At any other edge the grant holds its value.
- R9: `grant_o` never has more than one bit set.
- R10: The position saturates at `frame_len_i`, so the window does not reopen without a new `sof_i`. A `sof_i` in the middle of a frame restarts the window at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start-of-frame strobe |
| frame_len_i | input | CNT_W | Frame length in clock cycles |
| frac_code_i | input | 2 | Periodic slice code (00 quarter, 01 half, 10 three quarters, 11 reserved) |
| sg_mode_i | input | 1 | Scatter/gather DMA operation enabled |
| per_active_i | input | 1 | At least one periodic endpoint is active |
| per_req_i | input | 1 | Periodic fetch request |
| np_req_i | input | 1 | Non-periodic fetch request |
| xfer_done_i | input | 1 | Current transfer completes this cycle |
| grant_o | output | 2 | One-hot grant: bit 0 periodic, bit 1 non-periodic |
| per_window_o | output | 1 | Periodic window open (registered) |
| code_err_o | output | 1 | Sticky flag: reserved slice code seen |

## Verification
The bench builds the block with an 8-bit position counter, so the reset value of the counter (255) sits well above every frame length used. This brings the case of no window before the first start-of-frame into reach. Frame lengths of 40 and 13 cycles keep each frame short, so many full frames and many passes through saturation fit into one run. The 13-cycle frame also makes the floor in the boundary product visible (three quarters gives 9, a quarter gives 3). Transfer completions arrive at several spacings, including none for a long stretch, so decision points fall both inside and outside the window.

// File: rtl/pft_pkg.sv
package pft_pkg;

  localparam logic [1:0] GNT_NONE = 2'b00;
  localparam logic [1:0] GNT_PER  = 2'b01;
  localparam logic [1:0] GNT_NP   = 2'b10;

  typedef enum logic [1:0] {
    SLICE_QUARTER = 2'b00,
    SLICE_HALF    = 2'b01,
    SLICE_3QTR    = 2'b10,
    SLICE_RSVD    = 2'b11
  } slice_code_e;

  // Number of frame quarters for a slice code; reserved falls back to one.
  function automatic logic [1:0] quarters_of(input logic [1:0] code);
    case (code)
      SLICE_HALF: quarters_of = 2'd2;
      SLICE_3QTR: quarters_of = 2'd3;
      default:    quarters_of = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/pft_frame_pos.sv
module pft_frame_pos #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic [CNT_W-1:0] frame_len_i,
  output logic [CNT_W-1:0] pos_o
);

  localparam logic [CNT_W-1:0] POS_IDLE = {CNT_W{1'b1}};

  logic [CNT_W-1:0] pos_q;

  // Reset parks the counter at its top value so no window opens before a frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= POS_IDLE;
    end else if (sof_i) begin
      pos_q <= '0;
    end else if (pos_q < frame_len_i) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/pft_window_calc.sv
module pft_window_calc
  import pft_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] frame_len_i,
  input  logic [1:0]       frac_code_i,
  input  logic             sg_mode_i,
  input  logic             per_active_i,
  input  logic [CNT_W-1:0] pos_i,
  output logic             win_now_o,
  output logic             win_q_o,
  output logic             err_q_o
);

  localparam int PROD_W = CNT_W + 2;

  logic [1:0]        quarters;
  logic [PROD_W-1:0] product;
  logic [PROD_W-1:0] boundary_full;
  logic [CNT_W-1:0]  boundary;
  logic              win_q;
  logic              err_q;

  assign quarters      = quarters_of(frac_code_i);
  assign product       = {2'b00, frame_len_i} * {{CNT_W{1'b0}}, quarters};
  assign boundary_full = product >> 2;
  assign boundary      = boundary_full[CNT_W-1:0];

  assign win_now_o = sg_mode_i && per_active_i && (pos_i < boundary);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      win_q <= win_now_o;
      if (frac_code_i == SLICE_RSVD) begin
        err_q <= 1'b1;
      end
    end
  end

  assign win_q_o = win_q;
  assign err_q_o = err_q;

endmodule

// File: rtl/pft_grant_sel.sv
module pft_grant_sel
  import pft_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       win_now_i,
  input  logic       per_req_i,
  input  logic       np_req_i,
  input  logic       xfer_done_i,
  output logic [1:0] grant_o
);

  logic [1:0] grant_q;
  logic [1:0] pick;
  logic       decide;

  assign decide = (grant_q == GNT_NONE) || xfer_done_i;

  always_comb begin
    pick = GNT_NONE;
    if (win_now_i) begin
      if (per_req_i)     pick = GNT_PER;
      else if (np_req_i) pick = GNT_NP;
    end else begin
      if (np_req_i)       pick = GNT_NP;
      else if (per_req_i) pick = GNT_PER;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= GNT_NONE;
    end else if (decide) begin
      grant_q <= pick;
    end
  end

  assign grant_o = grant_q;

endmodule

// File: rtl/pft_arbiter.sv
module pft_arbiter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic [CNT_W-1:0] frame_len_i,
  input  logic [1:0]       frac_code_i,
  input  logic             sg_mode_i,
  input  logic             per_active_i,
  input  logic             per_req_i,
  input  logic             np_req_i,
  input  logic             xfer_done_i,
  output logic [1:0]       grant_o,
  output logic             per_window_o,
  output logic             code_err_o
);

  logic [CNT_W-1:0] pos;
  logic             win_now;

  pft_frame_pos #(.CNT_W(CNT_W)) u_pos (
    .clk         (clk),
    .rst         (rst),
    .sof_i       (sof_i),
    .frame_len_i (frame_len_i),
    .pos_o       (pos)
  );

  pft_window_calc #(.CNT_W(CNT_W)) u_win (
    .clk          (clk),
    .rst          (rst),
    .frame_len_i  (frame_len_i),
    .frac_code_i  (frac_code_i),
    .sg_mode_i    (sg_mode_i),
    .per_active_i (per_active_i),
    .pos_i        (pos),
    .win_now_o    (win_now),
    .win_q_o      (per_window_o),
    .err_q_o      (code_err_o)
  );

  pft_grant_sel u_gnt (
    .clk         (clk),
    .rst         (rst),
    .win_now_i   (win_now),
    .per_req_i   (per_req_i),
    .np_req_i    (np_req_i),
    .xfer_done_i (xfer_done_i),
    .grant_o     (grant_o)
  );

endmodule

// File: rtl/pft_arbiter_chk.sv
module pft_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] frac_code_i,
  input logic       sg_mode_i,
  input logic       per_active_i,
  input logic       per_req_i,
  input logic       np_req_i,
  input logic       xfer_done_i,
  input logic [1:0] grant_o,
  input logic       per_window_o,
  input logic       code_err_o
);

  a_r9_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  a_r8_grant_hold: assert property (@(posedge clk) disable iff (rst)
    (grant_o != 2'b00 && !xfer_done_i) |=> $stable(grant_o));

  a_r3_err_set: assert property (@(posedge clk) disable iff (rst)
    (frac_code_i == 2'b11) |=> code_err_o);

  a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst)
    code_err_o |=> code_err_o);

  a_r4_no_window_without_sg: assert property (@(posedge clk) disable iff (rst)
    !sg_mode_i |=> !per_window_o);

  a_r5_no_window_when_idle: assert property (@(posedge clk) disable iff (rst)
    !per_active_i |=> !per_window_o);

  a_r6_periodic_first: assert property (@(posedge clk) disable iff (rst)
    ((grant_o == 2'b00 || xfer_done_i) && per_req_i)
      |=> (!per_window_o || grant_o == 2'b01));

  a_r7_nonperiodic_first: assert property (@(posedge clk) disable iff (rst)
    ((grant_o == 2'b00 || xfer_done_i) && np_req_i)
      |=> (per_window_o || grant_o == 2'b10));

endmodule

bind pft_arbiter pft_arbiter_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .frac_code_i  (frac_code_i),
  .sg_mode_i    (sg_mode_i),
  .per_active_i (per_active_i),
  .per_req_i    (per_req_i),
  .np_req_i     (np_req_i),
  .xfer_done_i  (xfer_done_i),
  .grant_o      (grant_o),
  .per_window_o (per_window_o),
  .code_err_o   (code_err_o)
);

// File: tb/pft_arbiter_tb.sv
`timescale 1ns/1ps
module pft_arbiter_tb;

  localparam int CNT_W = 8;
  localparam int POS_IDLE = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sof = 1'b0;
  logic [CNT_W-1:0] flen = '0;
  logic [1:0]       code = 2'b00;
  logic             sg = 1'b0;
  logic             pa = 1'b0;
  logic             preq = 1'b0;
  logic             npreq = 1'b0;
  logic             done = 1'b0;
  logic [1:0]       grant;
  logic             win;
  logic             err;

  always #5 clk = ~clk;

  pft_arbiter #(.CNT_W(CNT_W)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .sof_i        (sof),
    .frame_len_i  (flen),
    .frac_code_i  (code),
    .sg_mode_i    (sg),
    .per_active_i (pa),
    .per_req_i    (preq),
    .np_req_i     (npreq),
    .xfer_done_i  (done),
    .grant_o      (grant),
    .per_window_o (win),
    .code_err_o   (err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  // Reference model state
  int         m_pos = POS_IDLE;
  logic [1:0] m_gnt = 2'b00;
  logic       m_win = 1'b0;
  logic       m_err = 1'b0;

  function automatic int quarters(input logic [1:0] c);
    if (c == 2'b01) return 2;
    if (c == 2'b10) return 3;
    return 1;
  endfunction

  // Drive one cycle of inputs, advance the model, queue the expected outputs.
  task automatic step(input string tag, input logic r, input logic s,
                      input logic p, input logic n, input logic d);
    int lim;
    logic wc;
    rst = r; sof = s; preq = p; npreq = n; done = d;
    lim = (int'(flen) * quarters(code)) >> 2;
    wc = sg && pa && (m_pos < lim);
    if (r) begin
      m_pos = POS_IDLE; m_gnt = 2'b00; m_win = 1'b0; m_err = 1'b0;
    end else begin
      if (code == 2'b11) m_err = 1'b1;
      if (m_gnt == 2'b00 || d) begin
        if (wc) m_gnt = p ? 2'b01 : (n ? 2'b10 : 2'b00);
        else    m_gnt = n ? 2'b10 : (p ? 2'b01 : 2'b00);
      end
      m_win = wc;
      if (s) m_pos = 0;
      else if (m_pos < int'(flen)) m_pos = m_pos + 1;
    end
    exp_q.push_back({m_gnt, m_win, m_err});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // pm/nm: 0 off, 1 on, 2 toggles every two cycles. dper: done period (0 = never).
  task automatic run(input string tag, input int ncyc, input int mid_sof,
                     input int pm, input int nm, input int dper);
    for (int c = 0; c < ncyc; c++) begin
      logic p, n, d, s;
      p = (pm == 1) || (pm == 2 && c[1]);
      n = (nm == 1) || (nm == 2 && !c[1]);
      d = (dper != 0) && ((c % dper) == dper - 1);
      s = (c == 0) || (c == mid_sof);
      step(tag, 1'b0, s, p, n, d);
    end
  endtask

  // Monitor: compare registered outputs shortly after each rising edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({grant, win, err} !== e) begin
        errors++;
        $display("FAIL %s: grant/win/err actual %b/%b/%b expected %b/%b/%b",
                 t, grant, win, err, e[3:2], e[1], e[0]);
      end
      checks++;
      if (!$onehot0(grant)) begin
        errors++;
        $display("FAIL R9: grant actual %b expected one-hot or zero", grant);
      end
    end
  end

  initial begin
    @(negedge clk);
    flen = 8'd40; code = 2'b00; sg = 1'b1; pa = 1'b1;
    for (int i = 0; i < 3; i++) step("R1", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step("R1", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // R2 quarter, half, three quarters of a 40-cycle frame, both requesting
    code = 2'b00; run("R2", 46, -1, 1, 1, 3);
    code = 2'b01; run("R2", 46, -1, 1, 1, 2);
    code = 2'b10; run("R2", 46, -1, 1, 1, 1);
    // R6 periodic priority in window with alternating requests
    code = 2'b10; run("R6", 46, -1, 2, 1, 1);
    run("R6", 46, -1, 0, 1, 2);
    // R7 non-periodic first after the window, toggling
    code = 2'b00; run("R7", 46, -1, 1, 2, 1);
    run("R7", 20, -1, 0, 0, 1);
    // R8 long burst with no completion
    code = 2'b01; run("R8", 30, -1, 1, 1, 0);
    run("R8", 20, -1, 1, 1, 7);
    // R10 short frame, saturation, mid-frame restart
    flen = 8'd13; code = 2'b10; run("R10", 40, -1, 1, 1, 1);
    run("R10", 40, 5, 1, 1, 1);
    code = 2'b00; run("R10", 30, 20, 2, 1, 1);
    // R4 no scatter/gather
    flen = 8'd40; code = 2'b10; sg = 1'b0; run("R4", 46, -1, 1, 1, 1);
    sg = 1'b1;
    // R5 no periodic endpoint active
    pa = 1'b0; code = 2'b10; run("R5", 46, -1, 1, 1, 1);
    pa = 1'b1;
    // R3 reserved code behaves as quarter and sets sticky flag
    code = 2'b11; run("R3", 46, -1, 1, 1, 1);
    code = 2'b01; run("R3", 46, -1, 1, 1, 1);
    step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run("R1", 10, -1, 1, 1, 1);
    step("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule